// File: doc/BRIEF.md
# Tagged Word Event Extractor

This block sits behind a time-to-digital converter readout path and turns a raw stream of 32-bit tagged words into whole, checked events. The top five bits of every word carry a type tag. The block waits for a global header, then gathers every word that follows, whatever its tag, until it sees a global trailer. The gathered words are kept in an internal buffer and are not released until the event is complete and has passed its check.

The check compares the 22-bit event number carried in the header with an expected number supplied from outside. The subtraction wraps at 2^22. When the two match, the buffered event goes out as one framed burst: the header first, the trailer last with a last marker, and the event length next to it. When they differ, the event is discarded and the number it carried is reported, so the consumer can take it as its new expectation. Fillers and any other words that arrive while no event is open are dropped one at a time. An event longer than the buffer is discarded with an overflow pulse, and the block goes back to looking for a header.

Top module: `tagged_event_extractor`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, and both skip_pulse and ovf_pulse are 0.
- R2: While no event is open, every word whose tag (bits 31:27) is not 01000 (global header) is dropped: it produces no output and no status pulse.
- R3: An event is the header word, every following word of any tag (including fillers 11000 and further 01000 words), and the first global trailer (tag 10000). The block emits all of these in arrival order, with the header first.
- R4: out_last is 1 only on the trailer word of a burst. evt_len equals the number of words in the event for the whole burst.
- R5: An event is delivered only when (header bits 26:5 minus expect_num) modulo 2^22 is zero. The value of expect_num is taken when the trailer is accepted. This also holds at the wrap values 0 and 0x3FFFFF.
- R6: A complete event whose number does not match is not emitted. skip_pulse is 1 for exactly the cycle after the trailer is accepted, and skip_num then holds the header's 22-bit number.
- R7: An event that holds exactly DEPTH words is delivered. When word DEPTH+1 of an open event is accepted, ovf_pulse is 1 for the next cycle, nothing is emitted, and the block drops words until the next header.
- R8: While a burst is being emitted, in_ready is 0. When out_ready is 0, out_data, out_last and out_valid hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Tagged readout word |
| in_ready | output | 1 | Block can accept a word |
| expect_num | input | 22 | Expected event number |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output event word |
| out_last | output | 1 | Marks the trailer word of a burst |
| out_ready | input | 1 | Consumer accepts the output word |
| evt_len | output | LEN_W | Word count of the event being emitted |
| skip_pulse | output | 1 | One-cycle pulse: event number did not match |
| skip_num | output | 22 | Number carried by the skipped event |
| ovf_pulse | output | 1 | One-cycle pulse: event exceeded the buffer |

## Verification
The first output word is due on the cycle after the clock edge that accepts the trailer, and the burst then moves one word per edge while out_ready is high. skip_pulse and ovf_pulse rise on that same edge after the deciding word and fall one edge later. The bench drives inputs and samples outputs on the falling edge. Its push task returns at the falling edge just after the accepting rising edge, so each result is read in the exact cycle it is due, and the pulses are checked again one cycle later to confirm they have fallen.

// File: rtl/evx_pkg.sv
// Package: word layout constants and tag codes shared by the extractor.
// Assumes 32-bit words with the tag in bits 31:27 and the event number in bits 26:5.
package evx_pkg;
    localparam int WORD_W  = 32;
    localparam int TAG_W   = 5;
    localparam int NUM_W   = 22;
    localparam int NUM_LSB = 5;

    typedef enum logic [TAG_W-1:0] {
        K_MEAS = 5'b00000,
        K_THDR = 5'b00001,
        K_TTRL = 5'b00011,
        K_TERR = 5'b00100,
        K_GHDR = 5'b01000,
        K_GTRL = 5'b10000,
        K_GTTT = 5'b10001,
        K_FILL = 5'b11000
    } kind_e;

    typedef enum logic [1:0] {
        ST_SEEK,
        ST_COLLECT,
        ST_EMIT
    } evx_state_e;
endpackage

// File: rtl/evx_store.sv
// Event store: one write port and one combinational read port.
// Assumes the controller never writes and reads the same event at once.
module evx_store #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [evx_pkg::WORD_W-1:0] wr_data,
    input  logic [AW-1:0]              rd_addr,
    output logic [evx_pkg::WORD_W-1:0] rd_data
);
    logic [evx_pkg::WORD_W-1:0] mem [DEPTH];

    // Store each accepted event word
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Present the word under the read pointer
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/evx_ctrl.sv
// Extractor control: finds the header, counts stored words, checks the event
// number modulo 2^NUM_W at the trailer, then emits or discards the event.
// Assumes in_tag/in_num are slices of the current input word.
module evx_ctrl
    import evx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [NUM_W-1:0] in_num,
    output logic             in_ready,
    input  logic [NUM_W-1:0] expect_num,
    input  logic             out_ready,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [AW-1:0]    rd_addr,
    output logic             emit,
    output logic             out_last,
    output logic [LEN_W-1:0] evt_len,
    output logic             skip_pulse,
    output logic [NUM_W-1:0] skip_num,
    output logic             ovf_pulse
);
    evx_state_e       st;
    logic [LEN_W-1:0] wcnt;
    logic [LEN_W-1:0] rcnt;
    logic [NUM_W-1:0] found;
    logic [NUM_W-1:0] diff;
    logic             acc, is_hdr, is_trl, full;

    // Decode handshake and tag of the current word
    always_comb begin
        acc    = in_valid && in_ready;
        is_hdr = (in_tag == K_GHDR);
        is_trl = (in_tag == K_GTRL);
        full   = (wcnt == LEN_W'(DEPTH));
        diff   = found - expect_num;
    end

    // Drive the store and output framing from the state
    always_comb begin
        in_ready = (st != ST_EMIT);
        emit     = (st == ST_EMIT);
        wr_en    = acc && (((st == ST_SEEK) && is_hdr) || ((st == ST_COLLECT) && !full));
        wr_addr  = (st == ST_SEEK) ? '0 : wcnt[AW-1:0];
        rd_addr  = rcnt[AW-1:0];
        out_last = emit && (rcnt == evt_len - LEN_W'(1));
    end

    // Sequence search, collection, check and emission
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_SEEK;
            wcnt       <= '0;
            rcnt       <= '0;
            found      <= '0;
            evt_len    <= '0;
            skip_pulse <= 1'b0;
            skip_num   <= '0;
            ovf_pulse  <= 1'b0;
        end else begin
            skip_pulse <= 1'b0;
            ovf_pulse  <= 1'b0;
            case (st)
                ST_SEEK: begin
                    if (acc && is_hdr) begin
                        found <= in_num;
                        wcnt  <= LEN_W'(1);
                        st    <= ST_COLLECT;
                    end
                end
                ST_COLLECT: begin
                    if (acc) begin
                        if (full) begin
                            ovf_pulse <= 1'b1;
                            st        <= ST_SEEK;
                        end else begin
                            wcnt <= wcnt + LEN_W'(1);
                            if (is_trl) begin
                                if (diff == '0) begin
                                    evt_len <= wcnt + LEN_W'(1);
                                    rcnt    <= '0;
                                    st      <= ST_EMIT;
                                end else begin
                                    skip_pulse <= 1'b1;
                                    skip_num   <= found;
                                    st         <= ST_SEEK;
                                end
                            end
                        end
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        if (out_last) st <= ST_SEEK;
                        else          rcnt <= rcnt + LEN_W'(1);
                    end
                end
                default: st <= ST_SEEK;
            endcase
        end
    end

    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        skip_pulse |-> !emit && in_ready); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> !emit && !skip_pulse); // R7
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> (evt_len >= LEN_W'(2)) && (evt_len <= LEN_W'(DEPTH))); // R4
endmodule

// File: rtl/tagged_event_extractor.sv
// Top: assembles header-to-trailer events from a tagged word stream, forwards
// events whose number matches expect_num, and reports skips and overflows.
// Assumes a ready/valid stream on both sides; DEPTH >= 2.
module tagged_event_extractor
    import evx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic [NUM_W-1:0]  expect_num,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic [LEN_W-1:0]  evt_len,
    output logic              skip_pulse,
    output logic [NUM_W-1:0]  skip_num,
    output logic              ovf_pulse
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;

    evx_ctrl #(.DEPTH(DEPTH), .AW(AW), .LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_tag     (in_data[WORD_W-1 -: TAG_W]),
        .in_num     (in_data[NUM_LSB +: NUM_W]),
        .in_ready   (in_ready),
        .expect_num (expect_num),
        .out_ready  (out_ready),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .emit       (out_valid),
        .out_last   (out_last),
        .evt_len    (evt_len),
        .skip_pulse (skip_pulse),
        .skip_num   (skip_num),
        .ovf_pulse  (ovf_pulse)
    );

    evx_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (in_data),
        .rd_addr (rd_addr),
        .rd_data (out_data)
    );

    AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R8
    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R8
    AST_LAST_IS_TRAILER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> out_data[WORD_W-1 -: TAG_W] == K_GTRL); // R4
    AST_HEAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (rd_addr == '0) |-> out_data[WORD_W-1 -: TAG_W] == K_GHDR); // R3
endmodule

// File: tb/tagged_event_extractor_test.sv
module tagged_event_extractor_test;
    localparam int  DEPTH = 16;
    localparam int  LEN_W = $clog2(DEPTH + 1);
    localparam time TCLK  = 10ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [31:0]      in_data = '0;
    logic             in_ready;
    logic [21:0]      expect_num = '0;
    logic             out_valid;
    logic [31:0]      out_data;
    logic             out_last;
    logic             out_ready = 1'b1;
    logic [LEN_W-1:0] evt_len;
    logic             skip_pulse;
    logic [21:0]      skip_num;
    logic             ovf_pulse;

    int total = 0;
    int bad = 0;
    logic [31:0] ev [0:31];

    always #(TCLK / 2) clk = ~clk;

    tagged_event_extractor #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .expect_num(expect_num), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
        .evt_len(evt_len), .skip_pulse(skip_pulse), .skip_num(skip_num),
        .ovf_pulse(ovf_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr_w(input logic [21:0] n);
        return {5'b01000, n, 5'b00000};
    endfunction

    function automatic logic [31:0] body_w(input int i, input int seed);
        logic [4:0] t;
        case ((i + seed) % 7)
            0: t = 5'b00000;
            1: t = 5'b00001;
            2: t = 5'b00100;
            3: t = 5'b00011;
            4: t = 5'b10001;
            5: t = 5'b11000;
            default: t = 5'b01000;
        endcase
        return {t, 27'(i * 977 + seed * 131)};
    endfunction

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic push(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic build(input logic [21:0] n, input int len, input int seed);
        ev[0] = hdr_w(n);
        for (int i = 1; i < len - 1; i++) ev[i] = body_w(i, seed);
        ev[len - 1] = {5'b10000, 27'(seed * 7 + len)};
    endtask

    task automatic send(input int len);
        for (int i = 0; i < len; i++) push(ev[i]);
    endtask

    task automatic drain(input int len);
        for (int i = 0; i < len; i++) begin
            chk(out_valid === 1'b1, "R3 valid", 32'(out_valid), 1);
            chk(out_data === ev[i], "R3 data", out_data, ev[i]);
            chk(out_last === (i == len - 1), "R4 last", 32'(out_last), 32'(i == len - 1));
            chk(evt_len === LEN_W'(len), "R4 len", 32'(evt_len), len);
            chk(in_ready === 1'b0, "R8 ready low", 32'(in_ready), 0);
            @(negedge clk);
        end
        chk(out_valid === 1'b0, "R3 burst end", 32'(out_valid), 0);
        chk(in_ready === 1'b1, "R3 ready back", 32'(in_ready), 1);
    endtask

    task automatic expect_skip(input logic [21:0] n);
        chk(skip_pulse === 1'b1, "R6 skip pulse", 32'(skip_pulse), 1);
        chk(skip_num === n, "R6 skip num", 32'(skip_num), 32'(n));
        chk(out_valid === 1'b0, "R6 no output", 32'(out_valid), 0);
        @(negedge clk);
        chk(skip_pulse === 1'b0, "R6 pulse one cycle", 32'(skip_pulse), 0);
        chk(out_valid === 1'b0, "R6 still no output", 32'(out_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready === 1'b1, "R1 in_ready", 32'(in_ready), 1);
        chk(out_valid === 1'b0, "R1 out_valid", 32'(out_valid), 0);
        chk(skip_pulse === 1'b0, "R1 skip", 32'(skip_pulse), 0);
        chk(ovf_pulse === 1'b0, "R1 ovf", 32'(ovf_pulse), 0);

        // R2 stray words of every non-header tag are dropped
        for (int t = 0; t < 32; t++) begin
            if (t == 8) continue;
            push({5'(t), 27'(t * 3001)});
            chk(out_valid === 1'b0 && skip_pulse === 1'b0 && ovf_pulse === 1'b0,
                "R2 stray dropped", {out_valid, skip_pulse, ovf_pulse}, 0);
        end
        expect_num = 22'd5;
        build(22'd5, 3, 1);
        send(3);
        drain(3); // R2 header after strays starts the event

        // R3 R4 R5 sweep over every length that fits, including DEPTH
        for (int len = 2; len <= DEPTH; len++) begin
            expect_num = 22'(len * 4099);
            build(22'(len * 4099), len, len);
            send(len);
            drain(len);
        end

        // R5 wrap values of the event number
        expect_num = 22'h3FFFFF;
        build(22'h3FFFFF, 4, 2);
        send(4);
        drain(4);
        expect_num = 22'h000000;
        build(22'h000000, 5, 3);
        send(5);
        drain(5);

        // R6 mismatches on both sides of the expected value, across the wrap
        expect_num = 22'h000000;
        build(22'h3FFFFF, 4, 4);
        send(4);
        expect_skip(22'h3FFFFF);
        expect_num = 22'h3FFFFF;
        build(22'h000000, 6, 5);
        send(6);
        expect_skip(22'h000000);
        expect_num = 22'h155555;
        build(22'h155556, 2, 6);
        send(2);
        expect_skip(22'h155556);
        // R5 expected value is sampled at the trailer, not at the header
        expect_num = 22'd100;
        build(22'd77, 4, 7);
        for (int i = 0; i < 3; i++) push(ev[i]);
        expect_num = 22'd77;
        push(ev[3]);
        drain(4);

        // R7 overflow: word DEPTH+1 of an open event
        expect_num = 22'd9;
        ev[0] = hdr_w(22'd9);
        for (int i = 1; i <= DEPTH; i++) ev[i] = {5'b00000, 27'(i)};
        for (int i = 0; i < DEPTH; i++) begin
            push(ev[i]);
            chk(ovf_pulse === 1'b0, "R7 no early overflow", 32'(ovf_pulse), 0);
        end
        push(ev[DEPTH]);
        chk(ovf_pulse === 1'b1, "R7 overflow pulse", 32'(ovf_pulse), 1);
        chk(out_valid === 1'b0, "R7 no output", 32'(out_valid), 0);
        @(negedge clk);
        chk(ovf_pulse === 1'b0, "R7 pulse one cycle", 32'(ovf_pulse), 0);
        push({5'b00001, 27'd1});
        push({5'b10000, 27'd2});
        chk(out_valid === 1'b0 && skip_pulse === 1'b0, "R7 tail dropped",
            {out_valid, skip_pulse}, 0);
        build(22'd9, 4, 8);
        send(4);
        drain(4); // R7 recovers on the next header

        // R8 backpressure holds the burst
        expect_num = 22'd33;
        build(22'd33, 4, 9);
        out_ready = 1'b0;
        send(4);
        for (int k = 0; k < 3; k++) begin
            chk(out_valid === 1'b1 && out_data === ev[0], "R8 hold", out_data, ev[0]);
            chk(in_ready === 1'b0, "R8 ready low on stall", 32'(in_ready), 0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        drain(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule